// File: doc/BRIEF.md
# One-Wire Bus Master Engine

This block is the timing engine for a single-wire, open-drain bus. It owns the bus waveform, and a controller above it only issues requests. A request is one of five operations: bus reset with presence detect, write one bit, read one bit, write one byte, or read one byte. The engine builds each operation from timed phases. In each phase the bus is either pulled low or released. The length of every phase is computed at elaboration from a clock-frequency parameter, so the same RTL runs from a fast or a slow clock without any hand-tuned constants. Drive and sense are separate pins. The drive output is inverted (high pulls the bus low), and the sense input passes through a synchroniser before it is sampled.

Ten phase lengths are used, in microseconds: A=6, B=64, C=60, D=10, E=9, F=55, G=0, H=480, I=70, J=410. The byte operations carry any 8-bit value, including the usual network-layer command bytes 0x33, 0x55, 0xCC and 0xF0. For devices powered from the bus, a write-byte request can also ask for an active-low strong pull-up. The pull-up engages once the last bit of that byte has been written.

The state machine has nine states:

- IDLE: waits for a legal request.
- RST_PRE: release for G.
- RST_LOW: drive low for H.
- RST_SETTLE: release for I, then sample presence.
- RST_TAIL: release for J.
- SLOT_LOW: the low part of a slot, A or C.
- SLOT_REL: the write recovery, B or D.
- RD_SETTLE: release for E, then sample.
- RD_TAIL: release for F.

The transitions are:

- IDLE to RST_PRE or SLOT_LOW on accept.
- RST_PRE to RST_LOW.
- RST_LOW to RST_SETTLE.
- RST_SETTLE to RST_TAIL.
- RST_TAIL to IDLE, which finishes the request.
- SLOT_LOW to SLOT_REL on a write, or to RD_SETTLE on a read.
- SLOT_REL to SLOT_LOW for the next bit, or to IDLE.
- RD_SETTLE to RD_TAIL.
- RD_TAIL to SLOT_LOW for the next bit, or to IDLE.

Each state leaves when its phase timer expires.

Top module: `owm_engine`

## Requirements
- R1: After reset: `busy`=0, `done`=0, `bus_drive`=0, `spu_n`=1, `presence`=0 and `rd_data`=0.
- R2: A request is accepted on a clock edge where `cmd_valid`=1, `busy`=0 and `cmd_op` is a legal code: 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte. `busy` reads 1 from the next cycle. A phase of t µs lasts max(1, floor(CLK_HZ·t/10^6)) cycles, and the first phase starts in the cycle after accept.
- R3: The reset request runs four phases: release for G, `bus_drive`=1 for H, release for I, release for J. The synchronised sense level is sampled at the end of I, and `presence`=1 if it was low.
- R4: A write slot for a 1 drives low for A and then releases for B. A write slot for a 0 drives low for C and then releases for D. Write bit sends `cmd_data[0]`.
- R5: A read slot drives low for A, releases for E, samples the sense level, and releases for F. Read bit returns the sample in `rd_data[0]`, with `rd_data[7:1]`=0.
- R6: The byte requests run eight back-to-back slots, least significant bit first. After a read byte, `rd_data[i]` holds the sample of slot i.
- R7: `done` is a single-cycle pulse. It appears in the cycle after the last phase, and in that cycle `busy`=0. `rd_data` changes only when a read request finishes. `presence` changes only during a reset request.
- R8: A request presented while `busy`=1 has no effect. So does an op code of 5, 6 or 7. The bus waveform and the results continue as if the request had not been made.
- R9: Take a write-byte request with `cmd_spu`=1, built with SPU_EN=1. `spu_n` goes to 0 in the `done` cycle and stays 0 until the cycle after the next accepted request. In every other case `spu_n`=1, and `cmd_spu` has no effect on other request types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request strobe |
| cmd_op | input | 3 | Operation code |
| cmd_data | input | 8 | Write data (bit 0 for write bit) |
| cmd_spu | input | 1 | Ask for strong pull-up after a write byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Result of the last read request |
| presence | output | 1 | Presence result of the last reset request |
| bus_drive | output | 1 | High pulls the bus low, low releases it |
| bus_sense | input | 1 | Bus level as seen at the pin |
| spu_n | output | 1 | Strong pull-up enable, active low |

## Verification
The bench compares the drive pin against a per-cycle model on every clock, so a phase that is one cycle long or short, or a 1 and 0 slot timing swapped, shows up at once as a drive mismatch. A responding device model pulls the bus low only during read slots and after a long reset pulse. A design that samples at the wrong point, inverts presence, or shifts read bits most-significant first would return wrong `rd_data` or `presence` values. Requests held during busy and illegal op codes are issued deliberately; a design that accepts them would restart the waveform. The pull-up is watched across idle cycles and into the next request, so a pull-up that never engages, engages on the wrong request type, or lingers into the next request is caught.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } owm_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_PRE,
        ST_RST_LOW,
        ST_RST_SETTLE,
        ST_RST_TAIL,
        ST_SLOT_LOW,
        ST_SLOT_REL,
        ST_RD_SETTLE,
        ST_RD_TAIL
    } owm_state_e;

    // Phase lengths in microseconds
    localparam longint unsigned US_A = 6;
    localparam longint unsigned US_B = 64;
    localparam longint unsigned US_C = 60;
    localparam longint unsigned US_D = 10;
    localparam longint unsigned US_E = 9;
    localparam longint unsigned US_F = 55;
    localparam longint unsigned US_G = 0;
    localparam longint unsigned US_H = 480;
    localparam longint unsigned US_I = 70;
    localparam longint unsigned US_J = 410;

    // Common network-layer command bytes
    localparam logic [7:0] NET_ID_READ  = 8'h33;
    localparam logic [7:0] NET_ADDR_ALL = 8'hCC;
    localparam logic [7:0] NET_ADDR_ONE = 8'h55;
    localparam logic [7:0] NET_ENUMERATE = 8'hF0;

    // Timer load value: a phase of t us lasts max(1, floor(hz*t/1e6)) cycles
    function automatic longint unsigned owm_load(input longint unsigned hz,
                                                 input longint unsigned us);
        longint unsigned t;
        t = (hz * us) / 64'd1000000;
        return (t == 0) ? 64'd0 : t - 64'd1;
    endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/owm_tick_timer.sv
module owm_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/owm_bit_shifter.sv
module owm_bit_shifter #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [W-1:0]         load_val,
    input  logic                 adv,
    input  logic                 cap,
    input  logic                 cap_bit,
    output logic                 cur_bit,
    output logic                 nxt_bit,
    output logic [W-1:0]         cap_next,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  sr;
    logic [IW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= load_val;
            cnt <= '0;
        end else if (adv) begin
            sr  <= {1'b0, sr[W-1:1]};
            cnt <= cnt + IW'(1);
        end else if (cap) begin
            sr  <= cap_next;
            cnt <= cnt + IW'(1);
        end
    end

    assign cur_bit  = sr[0];
    assign nxt_bit  = sr[1];
    assign cap_next = {cap_bit, sr[W-1:1]};
    assign idx      = cnt;
endmodule

// File: rtl/owm_engine.sv
module owm_engine
    import owm_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 50_000_000,
    parameter int              SYNC_STAGES = 2,
    parameter bit              SPU_EN      = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_spu,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       presence,
    output logic       bus_drive,
    input  logic       bus_sense,
    output logic       spu_n
);
    localparam longint unsigned LD_A = owm_load(CLK_HZ, US_A);
    localparam longint unsigned LD_B = owm_load(CLK_HZ, US_B);
    localparam longint unsigned LD_C = owm_load(CLK_HZ, US_C);
    localparam longint unsigned LD_D = owm_load(CLK_HZ, US_D);
    localparam longint unsigned LD_E = owm_load(CLK_HZ, US_E);
    localparam longint unsigned LD_F = owm_load(CLK_HZ, US_F);
    localparam longint unsigned LD_G = owm_load(CLK_HZ, US_G);
    localparam longint unsigned LD_H = owm_load(CLK_HZ, US_H);
    localparam longint unsigned LD_I = owm_load(CLK_HZ, US_I);
    localparam longint unsigned LD_J = owm_load(CLK_HZ, US_J);
    localparam int CNT_W = $clog2(LD_H + 2);
    localparam int IDX_W = $clog2(DATA_W);

    owm_state_e state_q, state_d;
    owm_op_e    op_q;

    logic             sense_s;
    logic             accept, legal;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_adv, sh_cap;
    logic             cur_bit, nxt_bit;
    logic [DATA_W-1:0] cap_next;
    logic [IDX_W-1:0] bit_idx;
    logic             pres_smp, rd_smp, finish;
    logic             smp_q, spu_req_q, spu_hold_q, done_q, pres_q;
    logic [DATA_W-1:0] rd_q;
    logic             is_read, is_byte, last_slot;

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_sense), .q(sense_s)
    );

    owm_tick_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    owm_bit_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(cmd_data),
        .adv(sh_adv), .cap(sh_cap), .cap_bit(smp_q),
        .cur_bit(cur_bit), .nxt_bit(nxt_bit), .cap_next(cap_next), .idx(bit_idx)
    );

    assign legal     = (cmd_op <= 3'd4);
    assign accept    = cmd_valid && legal && (state_q == ST_IDLE);
    assign is_read   = (op_q == OP_RBIT) || (op_q == OP_RBYTE);
    assign is_byte   = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);
    assign last_slot = !is_byte || (bit_idx == IDX_W'(DATA_W - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and phase sequencing
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        sh_cap   = 1'b0;
        pres_smp = 1'b0;
        rd_smp   = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    unique case (cmd_op)
                        OP_RESET: begin
                            state_d = ST_RST_PRE;
                            tmr_val = CNT_W'(LD_G);
                        end
                        OP_WBIT, OP_WBYTE: begin
                            state_d = ST_SLOT_LOW;
                            tmr_val = cmd_data[0] ? CNT_W'(LD_A) : CNT_W'(LD_C);
                        end
                        default: begin
                            state_d = ST_SLOT_LOW;
                            tmr_val = CNT_W'(LD_A);
                        end
                    endcase
                end
            end
            ST_RST_PRE: begin
                if (tmr_exp) begin
                    state_d  = ST_RST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LD_H);
                end
            end
            ST_RST_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_RST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LD_I);
                end
            end
            ST_RST_SETTLE: begin
                if (tmr_exp) begin
                    pres_smp = 1'b1;
                    state_d  = ST_RST_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LD_J);
                end
            end
            ST_RST_TAIL: begin
                if (tmr_exp) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SLOT_LOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (is_read) begin
                        state_d = ST_RD_SETTLE;
                        tmr_val = CNT_W'(LD_E);
                    end else begin
                        state_d = ST_SLOT_REL;
                        tmr_val = cur_bit ? CNT_W'(LD_B) : CNT_W'(LD_D);
                    end
                end
            end
            ST_SLOT_REL: begin
                if (tmr_exp) begin
                    sh_adv = 1'b1;
                    if (last_slot) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_SLOT_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = nxt_bit ? CNT_W'(LD_A) : CNT_W'(LD_C);
                    end
                end
            end
            ST_RD_SETTLE: begin
                if (tmr_exp) begin
                    rd_smp   = 1'b1;
                    state_d  = ST_RD_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LD_F);
                end
            end
            ST_RD_TAIL: begin
                if (tmr_exp) begin
                    sh_cap = 1'b1;
                    if (last_slot) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_SLOT_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(LD_A);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Result and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_RESET;
            spu_req_q  <= 1'b0;
            spu_hold_q <= 1'b0;
            smp_q      <= 1'b1;
            done_q     <= 1'b0;
            pres_q     <= 1'b0;
            rd_q       <= '0;
        end else begin
            done_q <= finish;
            if (accept) begin
                op_q       <= owm_op_e'(cmd_op);
                spu_req_q  <= cmd_spu;
                spu_hold_q <= 1'b0;
            end
            if (pres_smp) pres_q <= !sense_s;
            if (rd_smp)   smp_q  <= sense_s;
            if (finish && is_read)
                rd_q <= is_byte ? cap_next : {{(DATA_W-1){1'b0}}, smp_q};
            if (finish && (op_q == OP_WBYTE) && spu_req_q)
                spu_hold_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_drive = (state_q == ST_RST_LOW) || (state_q == ST_SLOT_LOW);
        done      = done_q;
        rd_data   = rd_q;
        presence  = pres_q;
    end

    if (SPU_EN) begin : g_spu
        assign spu_n = !spu_hold_q;
    end else begin : g_no_spu
        logic spu_unused;
        assign spu_unused = spu_hold_q;
        assign spu_n      = 1'b1 | spu_unused;
    end
endmodule

// File: rtl/owm_engine_chk.sv
module owm_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic [7:0] rd_data,
    input logic       presence,
    input logic       bus_drive,
    input logic       spu_n
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_drive);

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op <= 3'd4) |=> busy);

    a_r8_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op > 3'd4) |=> !busy);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_rd_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);

    a_r3_presence_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> busy);

    a_r9_spu_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !spu_n |-> (!busy && !bus_drive));
endmodule

bind owm_engine owm_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .rd_data(rd_data), .presence(presence),
    .bus_drive(bus_drive), .spu_n(spu_n)
);

// File: tb/owm_engine_tb_top.sv
module owm_engine_tb_top;
    localparam int              CLK_PERIOD = 10;
    localparam longint unsigned TB_HZ      = 1_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_spu = 1'b0;
    logic       busy, done, presence, bus_drive, spu_n;
    logic [7:0] rd_data;
    logic       slave_low = 1'b0;
    logic       bus_sense;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_sense = !(bus_drive || slave_low);

    owm_engine #(.CLK_HZ(TB_HZ), .SYNC_STAGES(2), .SPU_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_spu(cmd_spu), .busy(busy), .done(done),
        .rd_data(rd_data), .presence(presence), .bus_drive(bus_drive),
        .bus_sense(bus_sense), .spu_n(spu_n)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- responding device model ----------------
    bit slave_present = 1'b0;
    bit slave_rd = 1'b0;
    bit sbits[$];
    int hold = 0;
    int pwait = 0;
    int low_len = 0;
    bit prev_drv = 1'b0;

    always @(negedge clk) begin
        if (hold > 0) hold--;
        if (pwait > 0) begin
            pwait--;
            if (pwait == 0) hold = 100;
        end
        if (bus_drive && !prev_drv) begin
            low_len = 0;
            if (slave_rd && sbits.size() > 0) begin
                if (!sbits.pop_front()) hold = 25;
            end
        end
        if (!bus_drive && prev_drv && low_len >= 400 && slave_present) pwait = 10;
        if (bus_drive) low_len++;
        prev_drv  = bus_drive;
        slave_low = (hold > 0);
    end

    // ---------------- reference model ----------------
    bit    q_drv[$];
    string q_tag[$];
    bit    chk_en = 1'b0;
    bit    fin_pending = 1'b0;
    bit    fin_spu = 1'b0;
    bit    spu_exp = 1'b0;
    logic [7:0] rd_exp = 8'd0;
    logic [7:0] rd_next = 8'd0;
    logic  pres_exp = 1'b0;
    logic  pres_next = 1'b0;

    function automatic int ticks(input longint unsigned us);
        longint unsigned t;
        t = (TB_HZ * us) / 1000000;
        return (t < 1) ? 1 : int'(t);
    endfunction

    task automatic push_phase(input bit drv, input longint unsigned us, input string tag);
        for (int k = 0; k < ticks(us); k++) begin
            q_drv.push_back(drv);
            q_tag.push_back(tag);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            if (q_drv.size() > 0) begin
                bit    d;
                string t;
                d = q_drv.pop_front();
                t = q_tag.pop_front();
                check(bus_drive === d, t, "bus_drive", int'(bus_drive), int'(d));
                check(busy === 1'b1, "R2", "busy", int'(busy), 1);
                check(done === 1'b0, "R7", "done early", int'(done), 0);
                check(spu_n === 1'b1, "R9", "spu_n busy", int'(spu_n), 1);
                if (q_drv.size() == 0) fin_pending = 1'b1;
            end else if (fin_pending) begin
                fin_pending = 1'b0;
                rd_exp   = rd_next;
                pres_exp = pres_next;
                spu_exp  = fin_spu;
                check(done === 1'b1, "R7", "done", int'(done), 1);
                check(busy === 1'b0, "R7", "busy at done", int'(busy), 0);
                check(rd_data === rd_exp, "R6", "rd_data", int'(rd_data), int'(rd_exp));
                check(presence === pres_exp, "R3", "presence", int'(presence), int'(pres_exp));
                check(spu_n === !spu_exp, "R9", "spu_n at done", int'(spu_n), int'(!spu_exp));
            end else begin
                check(busy === 1'b0, "R8", "busy idle", int'(busy), 0);
                check(done === 1'b0, "R7", "done idle", int'(done), 0);
                check(bus_drive === 1'b0, "R8", "bus_drive idle", int'(bus_drive), 0);
                check(rd_data === rd_exp, "R7", "rd_data hold", int'(rd_data), int'(rd_exp));
                check(presence === pres_exp, "R7", "presence hold", int'(presence), int'(pres_exp));
                check(spu_n === !spu_exp, "R9", "spu_n idle", int'(spu_n), int'(!spu_exp));
            end
        end
    end

    // Issue one request; for reads, data is the byte the device returns.
    task automatic run_cmd(input logic [2:0] op, input logic [7:0] data,
                           input logic spu, input int hold_extra);
        if (op == 3'd2 || op == 3'd4) begin
            slave_rd = 1'b1;
            for (int i = 0; i < ((op == 3'd4) ? 8 : 1); i++) sbits.push_back(data[i]);
        end else begin
            slave_rd = 1'b0;
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        cmd_spu   = spu;
        @(posedge clk);
        #1;
        if (op <= 3'd4) begin
            spu_exp   = 1'b0;
            fin_spu   = (op == 3'd3) && spu;
            rd_next   = rd_exp;
            pres_next = pres_exp;
            unique case (op)
                3'd0: begin
                    push_phase(1'b0, 0,   "R3");
                    push_phase(1'b1, 480, "R3");
                    push_phase(1'b0, 70,  "R3");
                    push_phase(1'b0, 410, "R3");
                    pres_next = slave_present;
                end
                3'd1: begin
                    push_phase(1'b1, data[0] ? 6 : 60, "R4");
                    push_phase(1'b0, data[0] ? 64 : 10, "R4");
                end
                3'd2: begin
                    push_phase(1'b1, 6,  "R5");
                    push_phase(1'b0, 9,  "R5");
                    push_phase(1'b0, 55, "R5");
                    rd_next = {7'd0, data[0]};
                end
                3'd3: begin
                    for (int i = 0; i < 8; i++) begin
                        push_phase(1'b1, data[i] ? 6 : 60, "R6");
                        push_phase(1'b0, data[i] ? 64 : 10, "R6");
                    end
                end
                default: begin
                    for (int i = 0; i < 8; i++) begin
                        push_phase(1'b1, 6,  "R6");
                        push_phase(1'b0, 9,  "R6");
                        push_phase(1'b0, 55, "R6");
                    end
                    rd_next = data;
                end
            endcase
        end
        if (hold_extra > 0) begin
            cmd_op   = 3'd0;
            cmd_data = 8'h00;
            repeat (hold_extra) @(posedge clk);
            #1;
        end
        cmd_valid = 1'b0;
        cmd_spu   = 1'b0;
        while (q_drv.size() > 0 || fin_pending) @(negedge clk);
        repeat (3) @(negedge clk);
        sbits.delete();
        slave_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1", "busy", int'(busy), 0);
        check(done === 1'b0, "R1", "done", int'(done), 0);
        check(bus_drive === 1'b0, "R1", "bus_drive", int'(bus_drive), 0);
        check(spu_n === 1'b1, "R1", "spu_n", int'(spu_n), 1);
        check(presence === 1'b0, "R1", "presence", int'(presence), 0);
        check(rd_data === 8'd0, "R1", "rd_data", int'(rd_data), 0);
        chk_en = 1'b1;

        slave_present = 1'b1;
        run_cmd(3'd0, 8'h00, 1'b0, 0);                 // R3 device answers
        slave_present = 1'b0;
        run_cmd(3'd0, 8'h00, 1'b0, 0);                 // R3 nobody answers
        run_cmd(3'd1, 8'h01, 1'b1, 0);                 // R4 write 1, R9 flag ignored
        run_cmd(3'd1, 8'hFE, 1'b0, 0);                 // R4 write 0
        run_cmd(3'd2, 8'h00, 1'b0, 0);                 // R5 read 0
        run_cmd(3'd2, 8'h01, 1'b0, 0);                 // R5 read 1
        run_cmd(3'd3, owm_pkg::NET_ADDR_ALL, 1'b0, 0); // R6 write byte
        run_cmd(3'd3, owm_pkg::NET_ADDR_ONE, 1'b1, 0); // R9 pull-up after byte
        repeat (20) @(negedge clk);                    // R9 pull-up held while idle
        run_cmd(3'd4, owm_pkg::NET_ENUMERATE, 1'b0, 0);// R6 read byte, R9 release
        run_cmd(3'd4, 8'h5A, 1'b1, 0);                 // R6 read byte, R9 flag ignored
        run_cmd(3'd3, owm_pkg::NET_ID_READ, 1'b0, 40); // R8 request held while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6;                // R8 illegal op
        @(negedge clk);
        cmd_op = 3'd7;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        run_cmd(3'd2, 8'h00, 1'b0, 0);                 // R2 accepted after illegal ops

        chk_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule